// File: doc/BRIEF.md
# Host-Bus Pixel Write Port

This block is the host side of a small display controller. It sits on an 8080-style parallel bus: chip select, a register-select line, a write strobe and a 16-bit data bus. A bus cycle with register-select low carries a command or register index. A cycle with register-select high carries data. Data is taken when the write strobe rises. The bus pins are assumed synchronous to `clk`, and a strobe edge is recognised when a low sample of `wr_n` is followed by a high one.

Outside pixel mode, data bytes fill a small bank of byte-wide configuration registers. The index advances after each byte, so one index cycle can be followed by a whole run of settings. The bank holds the drawing window, the memory row pitch and the base address of the write area. Command 0xC1 switches to pixel mode. In pixel mode, data cycles are gathered into 18-bit RGB pixels over one, two or three beats. The number of beats depends on a bus-width select and a colour-depth pin. Each pixel goes out on a valid/ready memory write port, at an address taken from a window position that steps by itself. The host therefore never sends pixel addresses.

The memory port is valid/ready and holds one write. While `mem_valid` is high and `mem_ready` is low, address and data stay frozen. The host bus cannot be stalled. A pixel that completes while a write is still waiting is therefore discarded, and the window position does not step for it.

Top module: `hostpix_wr`

## Requirements
- R1: After reset `mem_valid` is low. The registers hold their defaults: window X 0..319, window Y 0..239, row pitch 320, base address 0.
- R2: An index cycle loads the register pointer. Each following data cycle outside pixel mode writes `db[7:0]` to the pointed register, then steps the pointer. Register order: 0/1 X start hi/lo, 2/3 X end hi/lo, 4/5 Y start hi/lo, 6/7 Y end hi/lo, 8/9 row pitch hi/lo, 10/11/12 base address bits 17:16, 15:8 and 7:0.
- R3: An index cycle with code 0xC1 enters pixel mode and moves the position to (X start, Y start). Any other index cycle, 0x80 included, leaves pixel mode. Data cycles outside pixel mode never produce a memory write.
- R4: With `bus_sel`=00 (or 11) and `color262`=0, one word is one pixel: R5 in `db[15:11]`, G6 in `db[10:5]`, B5 in `db[4:0]`. A 5-bit field widens to 6 bits by appending a copy of its top bit.
- R5: With `bus_sel`=00 and `color262`=1, the first word gives R[5:4] in `db[1:0]`. The second word gives R[3:0], G, B in `db[15:0]`.
- R6: With `bus_sel`=01, two 9-bit beats form a pixel whatever `color262` is. The first beat gives R6 and G[5:3] in `db[8:0]`. The second gives G[2:0] and B6.
- R7: With `bus_sel`=10 and `color262`=0, the first byte gives R5 and G[5:3]. The second byte gives G[2:0] and B5. Both are taken from `db[7:0]`, and 5-bit fields widen as in R4.
- R8: With `bus_sel`=10 and `color262`=1, three bytes form a pixel: R[5:4]; then R[3:0] and G[5:2]; then G[1:0] and B6.
- R9: Each write address is base + y × pitch + x, truncated to 18 bits.
- R10: After each accepted pixel, x steps by one. At X end, x returns to X start and y steps. After the Y end row, the position wraps to the window start.
- R11: The beat count clears whenever `cs_n` is high or `rs` is low, so a partly sent pixel is discarded.
- R12: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold. A pixel that completes in that state is dropped without moving the position.
- R13: Strobe edges with `cs_n` high have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Bus chip select, active low |
| rs | input | 1 | 0 = index/command cycle, 1 = data cycle |
| wr_n | input | 1 | Write strobe, data taken on its rising edge |
| db | input | 16 | Host data bus |
| bus_sel | input | 2 | Bus width: 00/11 = 16, 01 = 9, 10 = 8 bits |
| color262 | input | 1 | 1 = 18-bit colour, 0 = 16-bit colour |
| mem_ready | input | 1 | Memory accepts the pending write |
| mem_valid | output | 1 | A write is pending |
| mem_addr | output | 18 | Write address |
| mem_data | output | 18 | Pixel {R6,G6,B6} |

## Verification
Two functions can land in the same cycle: a pixel can complete on the host bus while the memory port is still holding the previous write. The bench provokes this by keeping `mem_ready` low across one complete pixel and then sending a second pixel. It judges the result by checking that the pending write is unchanged. It then releases the stall and checks that the next pixel lands at the address right after the first, which proves the dropped pixel did not advance the window position.

// File: rtl/hostpix_pkg.sv
package hostpix_pkg;

  typedef enum logic [1:0] {
    BUS_W16  = 2'b00,
    BUS_W9   = 2'b01,
    BUS_W8   = 2'b10,
    BUS_W16B = 2'b11
  } bus_width_e;

  localparam logic [7:0] CMD_PIX_ON = 8'hC1;
  localparam int         REG_COUNT  = 13;

  // Reset value of each configuration byte.
  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      2:       return 8'h01;
      3:       return 8'h3F;
      7:       return 8'hEF;
      8:       return 8'h01;
      9:       return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  // Widen a 5-bit colour field to 6 bits by repeating its top bit.
  function automatic logic [5:0] widen5(input logic [4:0] v);
    return {v, v[4]};
  endfunction

endpackage

// File: rtl/hostpix_regs.sv
module hostpix_regs
  import hostpix_pkg::*;
#(
  parameter int CRD_W  = 10,
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load,
  input  logic [7:0]        ptr_val,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [CRD_W-1:0]  xs,
  output logic [CRD_W-1:0]  xe,
  output logic [CRD_W-1:0]  ys,
  output logic [CRD_W-1:0]  ye,
  output logic [CRD_W-1:0]  pitch,
  output logic [ADDR_W-1:0] wbase
);

  logic [7:0] bank [REG_COUNT];
  logic [7:0] ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < REG_COUNT; i++) bank[i] <= reg_default(i);
    end else if (ptr_load) begin
      ptr <= ptr_val;
    end else if (wr_en) begin
      if (ptr < 8'(REG_COUNT)) bank[ptr[3:0]] <= wdata;
      ptr <= ptr + 8'd1;
    end
  end

  logic [15:0] xs16, xe16, ys16, ye16, pitch16;
  logic [23:0] base24;

  assign xs16    = {bank[0], bank[1]};
  assign xe16    = {bank[2], bank[3]};
  assign ys16    = {bank[4], bank[5]};
  assign ye16    = {bank[6], bank[7]};
  assign pitch16 = {bank[8], bank[9]};
  assign base24  = {bank[10], bank[11], bank[12]};

  assign xs    = xs16[CRD_W-1:0];
  assign xe    = xe16[CRD_W-1:0];
  assign ys    = ys16[CRD_W-1:0];
  assign ye    = ye16[CRD_W-1:0];
  assign pitch = pitch16[CRD_W-1:0];
  assign wbase = base24[ADDR_W-1:0];

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ptr_load) |=> (ptr == $past(ptr) + 8'd1));

  p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> (ptr == $past(ptr_val)));

endmodule

// File: rtl/hostpix_pack.sv
module hostpix_pack
  import hostpix_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        beat_en,
  input  logic [15:0] db,
  input  logic        color262,
  input  logic [1:0]  bus_sel,
  output logic        pix_done,
  output logic [17:0] pix_data
);

  bus_width_e  bw;
  logic [1:0]  beat;
  logic [1:0]  need;
  logic        last;
  logic [15:0] acc;

  assign bw = bus_width_e'(bus_sel);

  always_comb begin
    case (bw)
      BUS_W9:  need = 2'd2;
      BUS_W8:  need = color262 ? 2'd3 : 2'd2;
      default: need = color262 ? 2'd2 : 2'd1;
    endcase
  end

  assign last     = (beat >= need - 2'd1);
  assign pix_done = beat_en && last;

  always_comb begin
    case (bw)
      BUS_W9:  pix_data = {acc[8:0], db[8:0]};
      BUS_W8:  pix_data = color262 ? {acc[9:8], acc[7:0], db[7:0]}
                                   : {widen5(acc[7:3]), acc[2:0], db[7:5], widen5(db[4:0])};
      default: pix_data = color262 ? {acc[1:0], db[15:0]}
                                   : {widen5(db[15:11]), db[10:5], widen5(db[4:0])};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat <= '0;
      acc  <= '0;
    end else if (clr) begin
      beat <= '0;
    end else if (beat_en) begin
      beat <= last ? 2'd0 : beat + 2'd1;
      acc  <= (bw == BUS_W8) ? {acc[7:0], db[7:0]} : db;
    end
  end

  p_beat_lim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    beat < 2'd3);

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (beat == 2'd0));

endmodule

// File: rtl/hostpix_walk.sv
module hostpix_walk #(
  parameter int CRD_W  = 10,
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pix_done,
  input  logic [17:0]       pix_data,
  input  logic [CRD_W-1:0]  xs,
  input  logic [CRD_W-1:0]  xe,
  input  logic [CRD_W-1:0]  ys,
  input  logic [CRD_W-1:0]  ye,
  input  logic [CRD_W-1:0]  pitch,
  input  logic [ADDR_W-1:0] wbase,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [17:0]       mem_data
);

  logic [CRD_W-1:0]  x, y;
  logic              accept;
  logic [ADDR_W-1:0] addr_now;

  assign accept   = pix_done && (!mem_valid || mem_ready);
  assign addr_now = wbase + ADDR_W'(y) * ADDR_W'(pitch) + ADDR_W'(x);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x         <= '0;
      y         <= '0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else begin
      if (start) begin
        x <= xs;
        y <= ys;
      end else if (accept) begin
        if (x == xe) begin
          x <= xs;
          y <= (y == ye) ? ys : y + 1'b1;
        end else begin
          x <= x + 1'b1;
        end
      end
      if (accept) begin
        mem_valid <= 1'b1;
        mem_addr  <= addr_now;
        mem_data  <= pix_data;
      end else if (mem_ready) begin
        mem_valid <= 1'b0;
      end
    end
  end

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  p_drain_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !pix_done) |=> !mem_valid);

  p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !start && x != xe) |=> (x == $past(x) + 1'b1));

  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !start && x == xe && y == ye) |=> (x == $past(xs) && y == $past(ys)));

endmodule

// File: rtl/hostpix_wr.sv
module hostpix_wr
  import hostpix_pkg::*;
#(
  parameter int CRD_W  = 10,
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rs,
  input  logic              wr_n,
  input  logic [15:0]       db,
  input  logic [1:0]        bus_sel,
  input  logic              color262,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [17:0]       mem_data
);

  logic wr_q;
  logic strobe;
  logic pix_mode;
  logic cmd_on;

  assign strobe = !cs_n && wr_n && !wr_q;
  assign cmd_on = strobe && !rs && (db[7:0] == CMD_PIX_ON);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q     <= 1'b1;
      pix_mode <= 1'b0;
    end else begin
      wr_q <= wr_n;
      if (strobe && !rs) pix_mode <= (db[7:0] == CMD_PIX_ON);
    end
  end

  logic [CRD_W-1:0]  xs, xe, ys, ye, pitch;
  logic [ADDR_W-1:0] wbase;
  logic              pix_done;
  logic [17:0]       pix_data;

  hostpix_regs #(.CRD_W(CRD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_load (strobe && !rs),
    .ptr_val  (db[7:0]),
    .wr_en    (strobe && rs && !pix_mode),
    .wdata    (db[7:0]),
    .xs       (xs),
    .xe       (xe),
    .ys       (ys),
    .ye       (ye),
    .pitch    (pitch),
    .wbase    (wbase)
  );

  hostpix_pack u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cs_n || !rs),
    .beat_en  (strobe && rs && pix_mode),
    .db       (db),
    .color262 (color262),
    .bus_sel  (bus_sel),
    .pix_done (pix_done),
    .pix_data (pix_data)
  );

  hostpix_walk #(.CRD_W(CRD_W), .ADDR_W(ADDR_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cmd_on),
    .pix_done  (pix_done),
    .pix_data  (pix_data),
    .xs        (xs),
    .xe        (xe),
    .ys        (ys),
    .ye        (ye),
    .pitch     (pitch),
    .wbase     (wbase),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data)
  );

  p_mode_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_mode) |-> $past(strobe && !rs && db[7:0] == CMD_PIX_ON));

  p_cs_gate_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(pix_mode));

endmodule

// File: tb/hostpix_wr_test.sv
module hostpix_wr_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        rs = 1'b1;
  logic        wr_n = 1'b1;
  logic [15:0] db = '0;
  logic [1:0]  bus_sel = 2'b00;
  logic        color262 = 1'b0;
  logic        mem_ready = 1'b0;
  logic        mem_valid;
  logic [17:0] mem_addr;
  logic [17:0] mem_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  hostpix_wr uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .wr_n(wr_n), .db(db),
    .bus_sel(bus_sel), .color262(color262), .mem_ready(mem_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  // fields: bus[70:69] c262[68] beats[67:66] b0[65:50] b1[49:34] b2[33:18] exp[17:0]
  localparam int NV = 10;
  localparam logic [70:0] VEC [NV] = '{
    {2'd0, 1'b0, 2'd1, 16'hF800, 16'h0000, 16'h0000, 18'h3F000},
    {2'd0, 1'b0, 2'd1, 16'h07E0, 16'h0000, 16'h0000, 18'h00FC0},
    {2'd0, 1'b0, 2'd1, 16'h0811, 16'h0000, 16'h0000, 18'h02023},
    {2'd0, 1'b1, 2'd2, 16'h0002, 16'h5A5A, 16'h0000, 18'h25A5A},
    {2'd1, 1'b1, 2'd2, 16'h01AB, 16'h00CD, 16'h0000, 18'h356CD},
    {2'd1, 1'b0, 2'd2, 16'h0001, 16'h01FF, 16'h0000, 18'h003FF},
    {2'd2, 1'b0, 2'd2, 16'h00F8, 16'h001F, 16'h0000, 18'h3F03F},
    {2'd2, 1'b0, 2'd2, 16'h0007, 16'h00E0, 16'h0000, 18'h00FC0},
    {2'd2, 1'b1, 2'd3, 16'h0003, 16'h00C3, 16'h003C, 18'h3C33C},
    {2'd2, 1'b1, 2'd3, 16'hFF01, 16'hAA00, 16'hBBFF, 18'h100FF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic beat(input logic r, input logic [15:0] d);
    @(negedge clk); cs_n = 1'b0; rs = r; db = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic beat_nocs(input logic r, input logic [15:0] d);
    @(negedge clk); cs_n = 1'b1; rs = r; db = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic release_cs();
    @(negedge clk); cs_n = 1'b1; rs = 1'b1;
  endtask

  task automatic take();
    @(negedge clk); mem_ready = 1'b1;
    @(negedge clk); mem_ready = 1'b0;
  endtask

  task automatic mode(input logic [1:0] b, input logic c);
    @(negedge clk); bus_sel = b; color262 = c;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int ex_x, ex_y;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid low after reset", 32'(mem_valid), 32'd0);

    // Defaults: window origin 0, pitch 320, base 0
    mode(2'b00, 1'b0);
    beat(1'b0, 16'h00C1);
    beat(1'b1, 16'hF800);
    chk("R1 default first address", 32'(mem_addr), 32'd0);
    chk("R4 red widen", 32'(mem_data), 32'h3F000);
    take();
    beat(1'b1, 16'h001F);
    chk("R9 default second address", 32'(mem_addr), 32'd1);
    chk("R4 blue widen", 32'(mem_data), 32'h0003F);
    take();

    // R2: one index cycle, 13 consecutive bytes
    // X 2..4, Y 1..2, pitch 10, base 256
    beat(1'b0, 16'h0000);
    beat(1'b1, 16'h0000); beat(1'b1, 16'h0002);
    beat(1'b1, 16'h0000); beat(1'b1, 16'h0004);
    beat(1'b1, 16'h0000); beat(1'b1, 16'h0001);
    beat(1'b1, 16'h0000); beat(1'b1, 16'h0002);
    beat(1'b1, 16'h0000); beat(1'b1, 16'h000A);
    beat(1'b1, 16'h0000); beat(1'b1, 16'h0001); beat(1'b1, 16'h0000);
    chk("R3 register data makes no write", 32'(mem_valid), 32'd0);

    // Vector walk: each entry restarts at window origin (2,1) -> 256+10+2
    for (int i = 0; i < NV; i++) begin
      logic [1:0] vb;
      string tag;
      vb = VEC[i][70:69];
      if (vb == 2'd1) tag = "R6";
      else if (vb == 2'd2) tag = VEC[i][68] ? "R8" : "R7";
      else tag = VEC[i][68] ? "R5" : "R4";
      mode(vb, VEC[i][68]);
      beat(1'b0, 16'h00C1);
      beat(1'b1, VEC[i][65:50]);
      if (VEC[i][67:66] > 2'd1) beat(1'b1, VEC[i][49:34]);
      if (VEC[i][67:66] > 2'd2) beat(1'b1, VEC[i][33:18]);
      chk($sformatf("%s vector %0d data", tag, i), 32'(mem_data), 32'(VEC[i][17:0]));
      chk($sformatf("R9 vector %0d address", i), 32'(mem_addr), 32'd268);
      take();
      release_cs();
    end

    // R10: walk the 3x2 window and wrap
    mode(2'b00, 1'b0);
    beat(1'b0, 16'h00C1);
    ex_x = 2; ex_y = 1;
    for (int k = 0; k < 7; k++) begin
      beat(1'b1, 16'(k));
      chk($sformatf("R10 walk step %0d", k), 32'(mem_addr), 32'(256 + ex_y * 10 + ex_x));
      take();
      if (ex_x == 4) begin
        ex_x = 2;
        ex_y = (ex_y == 2) ? 1 : ex_y + 1;
      end else ex_x = ex_x + 1;
    end
    release_cs();

    // R11: partial pixel dropped on chip-select release
    mode(2'b10, 1'b1);
    beat(1'b0, 16'h00C1);
    beat(1'b1, 16'h0003);
    release_cs();
    beat(1'b1, 16'h0001); beat(1'b1, 16'h0000); beat(1'b1, 16'h00FF);
    chk("R11 cs release clears beats", 32'(mem_data), 32'h100FF);
    take();
    // partial pixel dropped on an rs-low cycle
    beat(1'b1, 16'h0002);
    beat(1'b0, 16'h00C1);
    beat(1'b1, 16'h0000); beat(1'b1, 16'h000F); beat(1'b1, 16'h00F0);
    chk("R11 rs low clears beats", 32'(mem_data), 32'h00FF0);
    chk("R11 restart address", 32'(mem_addr), 32'd268);
    take();
    release_cs();

    // R12: completion during a stall
    mode(2'b00, 1'b0);
    beat(1'b0, 16'h00C1);
    beat(1'b1, 16'hF800);
    repeat (3) @(negedge clk);
    chk("R12 valid held", 32'(mem_valid), 32'd1);
    chk("R12 data held", 32'(mem_data), 32'h3F000);
    beat(1'b1, 16'h07E0);
    chk("R12 stalled write unchanged", 32'(mem_data), 32'h3F000);
    chk("R12 stalled address unchanged", 32'(mem_addr), 32'd268);
    take();
    chk("R12 valid drops after ready", 32'(mem_valid), 32'd0);
    beat(1'b1, 16'h001F);
    chk("R12 dropped pixel did not advance", 32'(mem_addr), 32'd269);
    chk("R12 next data", 32'(mem_data), 32'h0003F);
    take();

    // R3: leaving pixel mode through a register index, rewrite base low byte
    beat(1'b0, 16'h000C);
    beat(1'b1, 16'h0005);
    chk("R3 no write outside pixel mode", 32'(mem_valid), 32'd0);
    beat(1'b0, 16'h00C1);
    beat(1'b1, 16'h0000);
    chk("R3 new base takes effect", 32'(mem_addr), 32'd273);
    take();
    beat(1'b0, 16'h0080);
    beat(1'b1, 16'h1234);
    chk("R3 0x80 stops pixel writes", 32'(mem_valid), 32'd0);

    // R13: strobe with chip select high is ignored
    beat_nocs(1'b0, 16'h00C1);
    beat(1'b1, 16'hF800);
    chk("R13 strobe without cs ignored", 32'(mem_valid), 32'd0);
    release_cs();

    finish_run();
  end

endmodule